// File: doc/BRIEF.md
# SMBus Byte-Access Register Slave

This block lets an external SMBus host read and write a small bank of byte-wide registers. It samples the SCL and SDA lines with the system clock. Each line passes through a two-flop synchronizer and a glitch filter. The block then finds clock edges and START, repeated START and STOP conditions on the filtered lines. The 7-bit slave address comes from input pins. The slave drives SDA only by pulling it low through an output enable and never holds SCL.

The block accepts two transactions and no others. In a Write Byte, the host sends the address with a write bit, a register index and one data byte, then a STOP. In a Read Byte, the host sends the address with a write bit and a register index, then a repeated START, then the address with a read bit. The slave returns one byte, which the host ends with a NACK and a STOP. A register changes only when a Write Byte ends cleanly with its STOP. A clock-low interval longer than a parameterised timeout makes the slave drop the transfer and release SDA.

Top module: `smb_byte_slave`

## Requirements
- R1: A Write Byte (START, own address with bit0=0, index, data, STOP) is acknowledged on all three bytes. It stores the data byte into the indexed register at the STOP, and not before.
- R2: A Read Byte (START, own address with bit0=0, index, repeated START, own address with bit0=1) acknowledges three bytes. It then shifts the indexed register out MSB first on SDA, one bit per SCL pulse.
- R3: Only the address on `dev_addr` is acknowledged. A byte with any other address gets no ACK (SDA stays released), the slave drives nothing until the next START, and no register changes.
- R4: The general call address 0000000 is never acknowledged, even when `dev_addr` is set to zero.
- R5: A write changes no register when it is cut short or malformed. This covers a STOP before the data byte, a repeated START after the data byte, and a fourth byte after the data byte. The fourth byte is not acknowledged.
- R6: A START followed directly by a STOP returns the slave to idle from any point of a transaction, without committing anything. The next transaction is then served normally.
- R7: If SCL stays low for more than `TIMEOUT_CYCLES` clocks while a transfer is in progress, the slave releases SDA, returns to idle and discards any pending write.
- R8: The slave works correctly when SCL low phases are stretched by another device, for any stretch shorter than the timeout. It changes SDA only while SCL is low.
- R9: Indices at or above `DEV_REGS` read back as 0x00, and writes to them are dropped. They do not alias onto implemented registers.
- R10: A pulse on SCL or SDA shorter than `FILT_STAGES` clock cycles is ignored.
- R11: An address byte with bit0=1 that does not follow a register index (a read with no index phase) is not acknowledged.
- R12: After reset, SDA is released and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SMBus clock line |
| sda_in | input | 1 | Sampled SMBus data line |
| dev_addr | input | 7 | Slave address select pins |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench drives full Write Byte and Read Byte frames with several data patterns (0xA5, 0x5A, 0xFF, 0x81) and at the lowest and highest implemented indices. These frames show whether bits are shifted in the correct order and whether the index is decoded correctly. Frames to a foreign address, to the general call address and to a changed pin address show whether address matching looks at the pins and applies the general-call exclusion. Truncated writes, writes followed by a repeated START or an extra byte, START-then-STOP resets and an over-long clock low all separate a commit at the STOP from an early commit. Stretched low phases and short SCL pulses show that bit sampling follows real clock edges only.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_HOLD,
        ST_IGNORE
    } smb_state_e;

    // which byte of the frame is being received
    typedef enum logic [1:0] {
        PH_ADDR_W,
        PH_INDEX,
        PH_WDATA,
        PH_ADDR_R
    } smb_phase_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam logic [6:0] GENERAL_CALL = 7'h00;

    function automatic logic addr_hit(input logic [7:0] rx,
                                      input logic [6:0] own,
                                      input logic       rw_bit);
        return (rx[7:1] == own) && (own != GENERAL_CALL) && (rx[0] == rw_bit);
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    logic [1:0]        sync_q;
    logic [STAGES-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            hist_q <= {hist_q[STAGES-2:0], sync_q[1]};
            if (&hist_q)
                clean <= 1'b1;
            else if (~|hist_q)
                clean <= 1'b0;
        end
    end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events
    import smb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_c,
    input  logic    sda_c,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_c;
            sda_q <= sda_c;
        end
    end

    always_comb begin
        ev.scl_lvl  = scl_c;
        ev.sda_lvl  = sda_c;
        ev.scl_rise = scl_c & ~scl_q;
        ev.scl_fall = ~scl_c & scl_q;
        ev.start    = scl_c & scl_q & sda_q & ~sda_c;
        ev.stop     = scl_c & scl_q & ~sda_q & sda_c;
    end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int REGS = 16,
    parameter int DW   = 8,
    parameter int IW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    localparam logic [IW:0] LIMIT = (IW+1)'(REGS);

    logic [REGS*DW-1:0] flat;

    for (genvar g = 0; g < REGS; g++) begin : g_cell
        logic [DW-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                cell_q <= wr_data;
        end
        assign flat[g*DW +: DW] = cell_q;
    end

    logic rd_in_range;
    assign rd_in_range = ({1'b0, rd_idx} < LIMIT);

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < REGS; k++) begin
            if (rd_in_range && (rd_idx == IW'(k)))
                rd_data = flat[k*DW +: DW];
        end
    end
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
    import smb_pkg::*;
#(
    parameter int TO_CYCLES = 2_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [6:0] own_addr,
    input  logic [7:0] rd_data,
    output logic [7:0] idx,
    output logic [7:0] wr_data,
    output logic       wr_en,
    output logic       sda_oe,
    output logic       timeout,
    output logic       idle
);
    localparam int          TW     = $clog2(TO_CYCLES + 1);
    localparam logic [TW-1:0] TO_LIM = TW'(TO_CYCLES);

    smb_state_e state_q;
    smb_phase_e phase_q;
    logic [3:0] bitcnt_q;
    logic [7:0] shift_q;
    logic [7:0] idx_q;
    logic [7:0] data_q;
    logic       pend_q;
    logic [TW-1:0] tmo_q;

    // clock-low watchdog, only while a transfer is active
    always_ff @(posedge clk) begin
        if (rst || (state_q == ST_IDLE) || ev.scl_lvl)
            tmo_q <= '0;
        else if (tmo_q != TO_LIM)
            tmo_q <= tmo_q + 1'b1;
    end

    assign timeout = (tmo_q == TO_LIM) && (state_q != ST_IDLE);
    assign wr_en   = ev.stop && (state_q == ST_HOLD) && pend_q;
    assign idle    = (state_q == ST_IDLE);
    assign idx     = idx_q;
    assign wr_data = data_q;
    assign sda_oe  = (state_q == ST_ACK) || ((state_q == ST_TX) && !shift_q[7]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            phase_q  <= PH_ADDR_W;
            bitcnt_q <= '0;
            shift_q  <= '0;
            idx_q    <= '0;
            data_q   <= '0;
            pend_q   <= 1'b0;
        end else if (timeout || ev.stop) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else if (ev.start) begin
            state_q  <= ST_RX;
            bitcnt_q <= '0;
            pend_q   <= 1'b0;
            // repeated START is legal only between index and data bytes
            if ((state_q == ST_RX) && (phase_q == PH_WDATA))
                phase_q <= PH_ADDR_R;
            else
                phase_q <= PH_ADDR_W;
        end else begin
            unique case (state_q)
                ST_RX: begin
                    if (ev.scl_rise) begin
                        shift_q  <= {shift_q[6:0], ev.sda_lvl};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (ev.scl_fall && (bitcnt_q == 4'd8)) begin
                        bitcnt_q <= '0;
                        unique case (phase_q)
                            PH_ADDR_W: state_q <= addr_hit(shift_q, own_addr, 1'b0) ? ST_ACK : ST_IGNORE;
                            PH_INDEX: begin
                                idx_q   <= shift_q;
                                state_q <= ST_ACK;
                            end
                            PH_WDATA: begin
                                data_q  <= shift_q;
                                pend_q  <= 1'b1;
                                state_q <= ST_ACK;
                            end
                            PH_ADDR_R: state_q <= addr_hit(shift_q, own_addr, 1'b1) ? ST_ACK : ST_IGNORE;
                            default: state_q <= ST_IGNORE;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt_q <= '0;
                        unique case (phase_q)
                            PH_ADDR_W: begin
                                phase_q <= PH_INDEX;
                                state_q <= ST_RX;
                            end
                            PH_INDEX: begin
                                phase_q <= PH_WDATA;
                                state_q <= ST_RX;
                            end
                            PH_WDATA: state_q <= ST_HOLD;
                            PH_ADDR_R: begin
                                shift_q <= rd_data;
                                state_q <= ST_TX;
                            end
                            default: state_q <= ST_IGNORE;
                        endcase
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt_q == 4'd7) begin
                            state_q <= ST_MACK;
                        end else begin
                            shift_q  <= {shift_q[6:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_fall)
                        state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    // any further clock pulse means more bytes: malformed
                    if (ev.scl_fall) begin
                        state_q <= ST_IGNORE;
                        pend_q  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smb_byte_slave.sv
module smb_byte_slave
    import smb_pkg::*;
#(
    parameter int DEV_REGS       = 16,
    parameter int FILT_STAGES    = 3,
    parameter int TIMEOUT_CYCLES = 2_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [6:0] dev_addr,
    output logic       sda_oe
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;

    assign raw_lines = {scl_in, sda_in};

    for (genvar i = 0; i < LINES; i++) begin : g_filt
        smb_line_filter #(.STAGES(FILT_STAGES)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_lines[i]),
            .clean (clean_lines[i])
        );
    end

    bus_ev_t ev;

    smb_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_c (clean_lines[1]),
        .sda_c (clean_lines[0]),
        .ev    (ev)
    );

    logic [7:0] idx;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       wr_en;
    logic       tmo_ev;
    logic       fsm_idle;

    smb_proto_fsm #(.TO_CYCLES(TIMEOUT_CYCLES)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .own_addr (dev_addr),
        .rd_data  (rd_data),
        .idx      (idx),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .sda_oe   (sda_oe),
        .timeout  (tmo_ev),
        .idle     (fsm_idle)
    );

    smb_regfile #(.REGS(DEV_REGS), .DW(8), .IW(8)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (wr_data),
        .rd_idx  (idx),
        .rd_data (rd_data)
    );

    logic scl_lvl;
    logic stop_ev;
    assign scl_lvl = ev.scl_lvl;
    assign stop_ev = ev.stop;
endmodule

// File: rtl/smb_slave_chk.sv
module smb_slave_chk (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic scl_lvl,
    input logic stop_ev,
    input logic wr_en,
    input logic timeout,
    input logic fsm_idle
);
    p_commit_at_stop_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> stop_ev);

    p_idle_released_r3: assert property (@(posedge clk) disable iff (rst)
        fsm_idle |-> !sda_oe);

    p_stop_idles_r6: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> fsm_idle);

    p_timeout_release_r7: assert property (@(posedge clk) disable iff (rst)
        timeout |=> (fsm_idle && !sda_oe));

    p_drive_in_low_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);
endmodule

bind smb_byte_slave smb_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .scl_lvl  (scl_lvl),
    .stop_ev  (stop_ev),
    .wr_en    (wr_en),
    .timeout  (tmo_ev),
    .fsm_idle (fsm_idle)
);

// File: tb/tb_smb_byte_slave.sv
module tb_smb_byte_slave;
    localparam int NREG = 16;
    localparam int TO   = 400;
    localparam int H    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [6:0] dev_addr = 7'h2C;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    smb_byte_slave #(.DEV_REGS(NREG), .FILT_STAGES(3), .TIMEOUT_CYCLES(TO)) dut (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_m),
        .sda_in   (sda_bus),
        .dev_addr (dev_addr),
        .sda_oe   (sda_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int extra_low = 0;
    int glitch_w  = 0;
    bit quiet = 1'b0;
    int quiet_hits = 0;
    logic [7:0] model [NREG];

    always @(negedge clk) if (quiet && sda_oe) quiet_hits++;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        sda_m = 1'b0; tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b;
        if (glitch_w > 0) begin
            tick(2);
            scl_m = 1'b1; tick(glitch_w);
            scl_m = 1'b0; tick(H/2 - 2 - glitch_w + extra_low);
        end else begin
            tick(H/2 + extra_low);
        end
        scl_m = 1'b1; tick(H/2);
        seen = sda_bus;
        tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, ack);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(nack, s);
    endtask

    function automatic bit owns(input logic [6:0] a);
        return (a == dev_addr) && (a != 7'h00);
    endfunction

    task automatic do_write(input logic [6:0] a, input logic [7:0] idx,
                            input logic [7:0] d, output int acks);
        logic k0, k1, k2;
        bus_start();
        send_byte({a, 1'b0}, k0);
        send_byte(idx, k1);
        send_byte(d, k2);
        bus_stop();
        acks = {29'd0, k0, k1, k2};
        if (owns(a) && (idx < NREG)) model[idx] = d;
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] idx,
                           output int val, output int acks);
        logic k0, k1, k2;
        logic [7:0] v;
        bus_start();
        send_byte({a, 1'b0}, k0);
        send_byte(idx, k1);
        bus_start();
        send_byte({a, 1'b1}, k2);
        recv_byte(1'b1, v);
        bus_stop();
        acks = {29'd0, k0, k1, k2};
        val  = int'(v);
    endtask

    function automatic int exp_rd(input int idx);
        return (idx < NREG) ? int'(model[idx]) : 0;
    endfunction

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v, acks;
        logic a, s;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        tick(6);
        rst = 1'b0;
        tick(4);

        // R12: reset state
        chk("R12 sda released after reset", sda_oe, 0);
        do_read(7'h2C, 8'd3, v, acks);
        chk("R12 register zero after reset", v, 0);
        chk("R2 read acks", acks, 0);

        // R1 / R2: patterns and boundary indices
        do_write(7'h2C, 8'd3, 8'hA5, acks);
        chk("R1 write acks", acks, 0);
        do_read(7'h2C, 8'd3, v, acks);
        chk("R1 readback idx3", v, exp_rd(3));
        do_write(7'h2C, 8'd15, 8'h5A, acks);
        do_read(7'h2C, 8'd15, v, acks);
        chk("R2 readback top idx", v, exp_rd(15));
        do_write(7'h2C, 8'd0, 8'hFF, acks);
        do_read(7'h2C, 8'd0, v, acks);
        chk("R2 readback idx0 all ones", v, exp_rd(0));
        do_write(7'h2C, 8'd7, 8'h81, acks);
        do_read(7'h2C, 8'd7, v, acks);
        chk("R2 readback idx7 edges", v, exp_rd(7));

        // R3: foreign address
        bus_start();
        send_byte({7'h2D, 1'b0}, a);
        quiet = 1'b1;
        chk("R3 foreign address not acked", a, 1);
        send_byte(8'd3, a);
        send_byte(8'h11, a);
        bus_stop();
        quiet = 1'b0;
        chk("R3 slave silent after mismatch", quiet_hits, 0);
        do_read(7'h2C, 8'd3, v, acks);
        chk("R3 no write from foreign frame", v, exp_rd(3));

        // R3: pins select the address
        dev_addr = 7'h51;
        tick(4);
        do_write(7'h51, 8'd2, 8'h33, acks);
        chk("R3 new pin address acked", acks, 0);
        do_read(7'h51, 8'd2, v, acks);
        chk("R3 readback at new address", v, exp_rd(2));
        bus_start();
        send_byte({7'h2C, 1'b0}, a);
        bus_stop();
        chk("R3 old address no longer acked", a, 1);

        // R4: general call
        bus_start();
        send_byte(8'h00, a);
        bus_stop();
        chk("R4 general call ignored", a, 1);
        dev_addr = 7'h00;
        tick(4);
        bus_start();
        send_byte(8'h00, a);
        bus_stop();
        chk("R4 general call ignored with zero pins", a, 1);
        dev_addr = 7'h2C;
        tick(4);

        // R5: truncated and malformed writes
        bus_start();
        send_byte({7'h2C, 1'b0}, a);
        send_byte(8'd3, a);
        bus_stop();
        do_read(7'h2C, 8'd3, v, acks);
        chk("R5 stop before data keeps reg", v, exp_rd(3));
        bus_start();
        send_byte({7'h2C, 1'b0}, a);
        send_byte(8'd3, a);
        send_byte(8'h77, a);
        bus_start();
        send_byte({7'h2C, 1'b0}, a);
        bus_stop();
        do_read(7'h2C, 8'd3, v, acks);
        chk("R5 restart after data keeps reg", v, exp_rd(3));
        bus_start();
        send_byte({7'h2C, 1'b0}, a);
        send_byte(8'd3, a);
        send_byte(8'h66, a);
        send_byte(8'h55, s);
        bus_stop();
        chk("R5 fourth byte not acked", s, 1);
        do_read(7'h2C, 8'd3, v, acks);
        chk("R5 four-byte frame keeps reg", v, exp_rd(3));

        // R11: read without index phase
        bus_start();
        send_byte({7'h2C, 1'b1}, a);
        bus_stop();
        chk("R11 bare read not acked", a, 1);

        // R6: START directly followed by STOP
        bus_start();
        send_byte({7'h2C, 1'b0}, a);
        send_byte(8'd3, a);
        bus_start();
        bus_stop();
        chk("R6 released after bus reset", sda_oe, 0);
        do_read(7'h2C, 8'd3, v, acks);
        chk("R6 no commit on bus reset", v, exp_rd(3));
        bus_start();
        bus_stop();
        do_write(7'h2C, 8'd9, 8'h3E, acks);
        chk("R6 next write served", acks, 0);
        do_read(7'h2C, 8'd9, v, acks);
        chk("R6 next write stored", v, exp_rd(9));

        // R7: clock held low past the timeout during data ACK
        bus_start();
        send_byte({7'h2C, 1'b0}, a);
        send_byte(8'd3, a);
        for (int i = 7; i >= 0; i--) clock_bit(((8'h99 >> i) & 8'h1) != 0, s);
        sda_m = 1'b1;
        tick(H/2);
        chk("R7 ack driven before timeout", sda_oe, 1);
        tick(TO + 40);
        chk("R7 sda released after timeout", sda_oe, 0);
        bus_stop();
        do_read(7'h2C, 8'd3, v, acks);
        chk("R7 pending write discarded", v, exp_rd(3));

        // R8: stretched low phases
        extra_low = 150;
        do_write(7'h2C, 8'd11, 8'hC6, acks);
        chk("R8 stretched write acks", acks, 0);
        do_read(7'h2C, 8'd11, v, acks);
        chk("R8 stretched readback", v, exp_rd(11));
        extra_low = 0;

        // R9: out-of-range index
        do_write(7'h2C, 8'd20, 8'h3C, acks);
        do_read(7'h2C, 8'd20, v, acks);
        chk("R9 out-of-range reads zero", v, 0);
        do_read(7'h2C, 8'd4, v, acks);
        chk("R9 no alias onto idx4", v, exp_rd(4));
        do_read(7'h2C, 8'd255, v, acks);
        chk("R9 idx255 reads zero", v, 0);

        // R10: short SCL pulses inside low phases
        glitch_w = 2;
        do_write(7'h2C, 8'd5, 8'hC3, acks);
        chk("R10 glitched write acks", acks, 0);
        glitch_w = 0;
        do_read(7'h2C, 8'd5, v, acks);
        chk("R10 glitches ignored", v, exp_rd(5));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule